// File: doc/BRIEF.md
# Multi-Stop Coarse Time-Interval Counter

This block is the digital coarse stage of a multi-channel time-interval measurement. A single free-running counter advances on every reference clock cycle, and all channels share it. After an arm pulse, the first start event stores the counter value together with an externally supplied fine interpolation code. Up to three stop pulses are then timestamped on both of their edges, again as a count plus a fine code. That gives seven capture channels in one measurement.

Each fine code counts interpolation steps from the event to the capturing clock edge. One reference period holds `STEPS` steps; the default of 5556 is roughly 9 ps per step at 20 MHz. The block reports, in fine steps, three start-to-rising-edge intervals and three rising-to-falling widths. Each value is the coarse cycle difference scaled by `STEPS`, corrected by the two fine codes. No table is used.

A programmable limit bounds the wait. An edge that has not arrived by then is flagged as timed out. A done flag rises once every enabled edge is resolved. The analog interpolators and the synchronisers are outside the block. Events arrive as one-cycle synchronous strobes, each with its fine code held alongside.

Top module: `multi_stop_interval_counter`

## Requirements
- R1: After reset, `done`, every bit of `interval_vld`, `width_vld`, `interval_to` and `width_to`, and every result word are 0. Start events are ignored until the first arm.
- R2: An `arm` pulse clears all results, valid bits, timeout bits and `done` by the following cycle. A start event in the same cycle as `arm` is ignored.
- R3: Only the first `start_evt` after an arm is captured. Later start events do not move any result.
- R4: Stop i's rising edge is accepted only in a cycle after the start capture. Its interval word `interval[i*RES_W +: RES_W]` equals (Dr − Ds)·STEPS + start_fine − rise_fine. Here Dr and Ds are the clock cycles of the two captures. `interval_vld[i]` rises the cycle after the capture.
- R5: Stop i's falling edge is accepted only in a cycle after its rising edge has been captured. Any earlier falling edge is ignored. Its width word `width[i*RES_W +: RES_W]` equals (Df − Dr)·STEPS + rise_fine − fall_fine.
- R6: Each edge channel keeps its first accepted event. Later events on that channel have no effect until the next arm.
- R7: Let E be the number of cycles elapsed since the start capture. A pending enabled edge is marked timed out (`interval_to[i]` / `width_to[i]`) in the first cycle where E ≥ `max_count`. An edge arriving in that cycle is rejected, so timeout takes priority.
- R8: A stop whose `stop_en[i]` is 0 never captures or times out, and it does not hold back `done`.
- R9: `done` is 1 while a start is captured and every enabled edge is either captured or timed out. It stays at 1 with all results unchanged until the next arm.
- R10: For any edge, its valid bit and its timeout bit are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Clears results and prepares for the next start |
| stop_en | input | NSTOP | Per-stop channel enable |
| max_count | input | CNT_W | Timeout limit in reference cycles after start |
| start_evt | input | 1 | Start event strobe |
| start_fine | input | FINE_W | Fine code of the start event |
| stop_rise | input | NSTOP | Rising-edge strobes of the stops |
| stop_rise_fine | input | NSTOP*FINE_W | Fine codes of the rising edges, stop i at bits i*FINE_W |
| stop_fall | input | NSTOP | Falling-edge strobes of the stops |
| stop_fall_fine | input | NSTOP*FINE_W | Fine codes of the falling edges |
| interval | output | NSTOP*RES_W | Start-to-rise intervals in fine steps |
| width | output | NSTOP*RES_W | Rise-to-fall widths in fine steps |
| interval_vld | output | NSTOP | Rising edge captured |
| width_vld | output | NSTOP | Falling edge captured |
| interval_to | output | NSTOP | Rising edge timed out |
| width_to | output | NSTOP | Falling edge timed out |
| done | output | 1 | Measurement complete |

## Verification
Two things can meet in one cycle: an edge strobe and the timeout limit. The bench provokes this with a short limit. One stop rises one cycle before the limit, and its falling edge lands exactly on the limit cycle. The rise must be kept and the fall must be flagged as timed out with no width. A second collision is also driven: stops strobed in the start cycle, and arm and start together. Each is judged against a behavioural model that is compared on every clock.

// File: rtl/multi_stop_interval_counter.sv
module multi_stop_interval_counter #(
  parameter int CNT_W  = 16,
  parameter int FINE_W = 13,
  parameter int STEPS  = 5556,
  parameter int NSTOP  = 3,
  localparam int RES_W = CNT_W + FINE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    arm,
  input  logic [NSTOP-1:0]        stop_en,
  input  logic [CNT_W-1:0]        max_count,
  input  logic                    start_evt,
  input  logic [FINE_W-1:0]       start_fine,
  input  logic [NSTOP-1:0]        stop_rise,
  input  logic [NSTOP*FINE_W-1:0] stop_rise_fine,
  input  logic [NSTOP-1:0]        stop_fall,
  input  logic [NSTOP*FINE_W-1:0] stop_fall_fine,
  output logic [NSTOP*RES_W-1:0]  interval,
  output logic [NSTOP*RES_W-1:0]  width,
  output logic [NSTOP-1:0]        interval_vld,
  output logic [NSTOP-1:0]        width_vld,
  output logic [NSTOP-1:0]        interval_to,
  output logic [NSTOP-1:0]        width_to,
  output logic                    done
);
  localparam logic [RES_W-1:0] STEP_V = RES_W'(STEPS);

  logic [CNT_W-1:0]  cnt, start_cnt;
  logic [FINE_W-1:0] start_fine_q;
  logic              waiting, started;
  logic [NSTOP-1:0]  resolved;

  wire [CNT_W-1:0] elapsed   = cnt - start_cnt;
  wire             in_window = started && (elapsed < max_count);
  wire             expired   = started && (elapsed >= max_count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt          <= '0;
      start_cnt    <= '0;
      start_fine_q <= '0;
      waiting      <= 1'b0;
      started      <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (arm) begin
        waiting <= 1'b1;
        started <= 1'b0;
      end else if (waiting && start_evt) begin
        waiting      <= 1'b0;
        started      <= 1'b1;
        start_cnt    <= cnt;
        start_fine_q <= start_fine;
      end
    end
  end

  for (genvar i = 0; i < NSTOP; i++) begin : g_stop
    logic              rise_got, rise_to, fall_got, fall_to;
    logic [CNT_W-1:0]  rise_cnt, fall_cnt;
    logic [FINE_W-1:0] rise_f, fall_f;

    wire rise_open = stop_en[i] && !rise_got && !rise_to;
    wire fall_open = stop_en[i] && !fall_got && !fall_to;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        {rise_got, rise_to, fall_got, fall_to} <= '0;
        rise_cnt <= '0;
        fall_cnt <= '0;
        rise_f   <= '0;
        fall_f   <= '0;
      end else if (arm) begin
        {rise_got, rise_to, fall_got, fall_to} <= '0;
      end else begin
        if (rise_open && in_window && stop_rise[i]) begin
          rise_got <= 1'b1;
          rise_cnt <= cnt;
          rise_f   <= stop_rise_fine[i*FINE_W +: FINE_W];
        end else if (rise_open && expired) begin
          rise_to <= 1'b1;
        end
        if (fall_open && rise_got && in_window && stop_fall[i]) begin
          fall_got <= 1'b1;
          fall_cnt <= cnt;
          fall_f   <= stop_fall_fine[i*FINE_W +: FINE_W];
        end else if (fall_open && expired) begin
          fall_to <= 1'b1;
        end
      end
    end

    assign resolved[i]     = !stop_en[i] || ((rise_got || rise_to) && (fall_got || fall_to));
    assign interval_vld[i] = rise_got;
    assign width_vld[i]    = fall_got;
    assign interval_to[i]  = rise_to;
    assign width_to[i]     = fall_to;

    assign interval[i*RES_W +: RES_W] = rise_got ?
      RES_W'(rise_cnt - start_cnt) * STEP_V + RES_W'(start_fine_q) - RES_W'(rise_f) : '0;
    assign width[i*RES_W +: RES_W] = fall_got ?
      RES_W'(fall_cnt - rise_cnt) * STEP_V + RES_W'(rise_f) - RES_W'(fall_f) : '0;
  end

  assign done = started && (&resolved);
endmodule

// File: rtl/multi_stop_interval_counter_chk.sv
module multi_stop_interval_counter_chk #(
  parameter int NSTOP = 3,
  parameter int RES_W = 29
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   arm,
  input logic                   done,
  input logic [NSTOP-1:0]       interval_vld,
  input logic [NSTOP-1:0]       width_vld,
  input logic [NSTOP-1:0]       interval_to,
  input logic [NSTOP-1:0]       width_to,
  input logic [NSTOP*RES_W-1:0] interval,
  input logic [NSTOP*RES_W-1:0] width
);
  // R10
  vld_to_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((interval_vld & interval_to) == '0) && ((width_vld & width_to) == '0));

  // R5
  width_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (width_vld & ~interval_vld) == '0);

  // R2
  arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!done && interval_vld == '0 && width_vld == '0 &&
             interval_to == '0 && width_to == '0));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> ($stable(interval) && $stable(width)));

  // R6
  vld_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> ((interval_vld & $past(interval_vld)) == $past(interval_vld)));
endmodule

bind multi_stop_interval_counter multi_stop_interval_counter_chk #(.NSTOP(NSTOP), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .done(done),
  .interval_vld(interval_vld), .width_vld(width_vld),
  .interval_to(interval_to), .width_to(width_to),
  .interval(interval), .width(width)
);

// File: tb/tb_multi_stop_interval_counter.sv
module tb_multi_stop_interval_counter;
  localparam int CNT_W = 16, FINE_W = 13, STEPS = 5556, NS = 3;
  localparam int RES_W = CNT_W + FINE_W;

  logic clk = 0, rst_n = 0, arm = 0, start_evt = 0;
  logic [NS-1:0] stop_en = '0, stop_rise = '0, stop_fall = '0;
  logic [CNT_W-1:0] max_count = '0;
  logic [FINE_W-1:0] start_fine = '0;
  logic [NS*FINE_W-1:0] stop_rise_fine = '0, stop_fall_fine = '0;
  logic [NS*RES_W-1:0] interval, width;
  logic [NS-1:0] interval_vld, width_vld, interval_to, width_to;
  logic done;

  multi_stop_interval_counter dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0, cmp_on = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model
  int mcyc, m_sc, m_sf;
  bit m_wait, m_started;
  bit mrg[NS], mrt[NS], mfg[NS], mft[NS];
  int mrc[NS], mrf[NS], mfc[NS], mff[NS];

  always @(posedge clk) begin
    if (!rst_n) begin
      mcyc = 0; m_wait = 0; m_started = 0; m_sc = 0; m_sf = 0;
      for (int i = 0; i < NS; i++) begin mrg[i] = 0; mrt[i] = 0; mfg[i] = 0; mft[i] = 0; end
    end else begin
      if (arm) begin
        m_wait = 1; m_started = 0;
        for (int i = 0; i < NS; i++) begin mrg[i] = 0; mrt[i] = 0; mfg[i] = 0; mft[i] = 0; end
      end else begin
        if (m_started) begin
          for (int i = 0; i < NS; i++) begin
            bit rg_old;
            int el;
            rg_old = mrg[i];
            el = mcyc - m_sc;
            if (stop_en[i] && !mrg[i] && !mrt[i]) begin
              if (el < max_count) begin
                if (stop_rise[i]) begin
                  mrg[i] = 1; mrc[i] = mcyc; mrf[i] = stop_rise_fine[i*FINE_W +: FINE_W];
                end
              end else mrt[i] = 1;
            end
            if (stop_en[i] && !mfg[i] && !mft[i]) begin
              if (el < max_count) begin
                if (rg_old && stop_fall[i]) begin
                  mfg[i] = 1; mfc[i] = mcyc; mff[i] = stop_fall_fine[i*FINE_W +: FINE_W];
                end
              end else mft[i] = 1;
            end
          end
        end
        if (m_wait && start_evt) begin
          m_wait = 0; m_started = 1; m_sc = mcyc; m_sf = start_fine;
        end
      end
      mcyc++;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      bit all_res;
      all_res = 1;
      for (int i = 0; i < NS; i++) begin
        longint ei, ew;
        if (stop_en[i] && !((mrg[i] || mrt[i]) && (mfg[i] || mft[i]))) all_res = 0;
        ei = mrg[i] ? longint'(mrc[i] - m_sc) * STEPS + m_sf - mrf[i] : 0;
        ew = mfg[i] ? longint'(mfc[i] - mrc[i]) * STEPS + mrf[i] - mff[i] : 0;
        chk(interval_vld[i] == mrg[i], "R4 interval_vld", interval_vld[i], mrg[i]);
        chk(width_vld[i] == mfg[i], "R5 width_vld", width_vld[i], mfg[i]);
        chk(interval_to[i] == mrt[i], "R7 interval_to", interval_to[i], mrt[i]);
        chk(width_to[i] == mft[i], "R7 width_to", width_to[i], mft[i]);
        chk(interval[i*RES_W +: RES_W] == ei, "R4 interval", interval[i*RES_W +: RES_W], ei);
        chk(width[i*RES_W +: RES_W] == ew, "R5 width", width[i*RES_W +: RES_W], ew);
      end
      chk(done == (m_started && all_res), "R9 done", done, m_started && all_res);
    end
  end

  task automatic nxt(int n);
    repeat (n) begin
      @(negedge clk); #1;
      arm = 0; start_evt = 0; stop_rise = '0; stop_fall = '0;
    end
  endtask

  function automatic longint ival(int i);
    return longint'(interval[i*RES_W +: RES_W]);
  endfunction
  function automatic longint wval(int i);
    return longint'(width[i*RES_W +: RES_W]);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: start before any arm
    start_evt = 1;
    chk(done == 0 && interval_vld == 0 && width_vld == 0 && interval_to == 0 && width_to == 0,
        "R1 reset state", done, 0);
    #1 rst_n = 1; cmp_on = 1;
    nxt(3);
    chk(done == 0, "R1 start ignored before arm", done, 0);

    // Scenario A: three stops, R4/R5
    stop_en = 3'b111; max_count = 16'd1000;
    arm = 1; nxt(2);
    start_evt = 1; start_fine = 13'd100; nxt(5);
    stop_rise_fine[0 +: FINE_W] = 13'd300; stop_rise[0] = 1; nxt(2);
    stop_rise_fine[FINE_W +: FINE_W] = 13'd50; stop_rise_fine[2*FINE_W +: FINE_W] = 13'd5000;
    stop_rise[1] = 1; stop_rise[2] = 1; stop_fall_fine[0 +: FINE_W] = 13'd10; stop_fall[0] = 1; nxt(1);
    chk(ival(0) == 5*5556 + 100 - 300, "R4 stop0 interval", ival(0), 5*5556 + 100 - 300);
    chk(wval(0) == 2*5556 + 300 - 10, "R5 stop0 width", wval(0), 2*5556 + 300 - 10);
    chk(ival(2) == 7*5556 + 100 - 5000, "R4 stop2 interval", ival(2), 7*5556 + 100 - 5000);
    // R6: repeated rise on stop0 ignored
    stop_rise_fine[0 +: FINE_W] = 13'd1; stop_rise[0] = 1; nxt(1);
    chk(ival(0) == 5*5556 + 100 - 300, "R6 repeat rise ignored", ival(0), 5*5556 + 100 - 300);
    stop_fall_fine[FINE_W +: FINE_W] = 13'd4000; stop_fall_fine[2*FINE_W +: FINE_W] = 13'd0;
    stop_fall[1] = 1; stop_fall[2] = 1; nxt(1);
    chk(wval(1) == 2*5556 + 50 - 4000, "R5 stop1 width", wval(1), 2*5556 + 50 - 4000);
    chk(done == 1, "R9 done after all edges", done, 1);
    start_evt = 1; stop_fall[0] = 1; nxt(4);
    chk(done == 1 && ival(1) == 7*5556 + 100 - 50, "R9 results held", ival(1), 7*5556 + 100 - 50);

    // Scenario B: arm+start together, second start, stops in start cycle, early fall
    arm = 1; start_evt = 1; nxt(1);
    chk(done == 0 && interval_vld == 0, "R2 arm clears", interval_vld, 0);
    nxt(2);
    stop_fall[0] = 1; start_evt = 1; start_fine = 13'd7; stop_rise[0] = 1; stop_rise_fine[0 +: FINE_W] = 13'd9; nxt(1);
    chk(interval_vld[0] == 0, "R4 stop in start cycle ignored", interval_vld[0], 0);
    stop_fall[0] = 1; nxt(2);
    chk(width_vld[0] == 0, "R5 fall before rise ignored", width_vld[0], 0);
    start_evt = 1; start_fine = 13'd2000; nxt(1);
    stop_rise[0] = 1; nxt(1);
    chk(ival(0) == 4*5556 + 7 - 9, "R3 second start ignored", ival(0), 4*5556 + 7 - 9);
    // R2: arm mid-measurement
    arm = 1; nxt(1);
    chk(interval_vld == 0 && done == 0, "R2 arm mid-run clears", interval_vld, 0);

    // Scenario C: timeout collision, disabled channel
    stop_en = 3'b011; max_count = 16'd20;
    arm = 1; nxt(1);
    start_evt = 1; start_fine = 13'd0; nxt(19);
    stop_rise[0] = 1; stop_rise[2] = 1; stop_rise_fine[0 +: FINE_W] = 13'd0; nxt(1);
    stop_fall[0] = 1; stop_fall[2] = 1; nxt(1);
    chk(interval_vld[0] == 1 && ival(0) == 19*5556, "R7 rise before limit kept", ival(0), 19*5556);
    chk(width_to[0] == 1 && width_vld[0] == 0, "R7 fall at limit timed out", width_to[0], 1);
    chk(interval_to[1] == 1 && width_to[1] == 1, "R7 silent stop timed out", interval_to[1], 1);
    chk(interval_to[0] == 0, "R10 captured edge not timed out", interval_to[0], 0);
    chk(interval_vld[2] == 0 && interval_to[2] == 0 && width_to[2] == 0, "R8 disabled stop", interval_vld[2], 0);
    chk(done == 1, "R8 done without disabled stop", done, 1);

    // Scenario D: zero limit
    max_count = 16'd0; stop_en = 3'b100;
    arm = 1; nxt(1);
    start_evt = 1; nxt(1);
    stop_rise[2] = 1; nxt(1);
    chk(interval_to[2] == 1 && interval_vld[2] == 0, "R7 zero limit", interval_to[2], 1);

    // Scenario E: no stops enabled
    stop_en = 3'b000; max_count = 16'd50;
    arm = 1; nxt(1);
    start_evt = 1; nxt(1);
    chk(done == 1, "R8 done with no stops", done, 1);
    nxt(3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule